// File: doc/BRIEF.md
# Infrared Remote Pulse Receiver

This block turns an already demodulated infrared remote-control signal into data bits. The line idles high and every symbol starts with a low pulse. The receiver samples the line on a sampling tick and measures two things in ticks: how long each low pulse lasts, and how far apart the falling edges are. It compares these against programmable 8-bit limits to find the start of a frame, decide each bit and spot the end of the frame.

When enabled, the receiver waits for a leader, which is a low pulse whose width falls inside a programmed window. A mode bit also lets a frame start with no leader: a short low pulse is then taken as the first data symbol. In both cases the falling-edge spacing decides each bit. A frame ends when no new falling edge arrives within the programmed maximum bit cycle. The finished frame is then posted on the data and bit-count outputs with a one-cycle completion pulse. A leader that is too wide raises a one-cycle error pulse instead.

Thresholds are written through a small synchronous register port. A frame in progress always keeps the values it started with.

Top module: `irrx_receiver`

## Requirements
- R1: After reset, busy, frameDone and leaderErr are 0, and rxData and rxBits are 0. While rxEnable is 0 the receiver does not start a frame and raises no flag.
- R2: In leader mode, a low pulse is a leader if its width in ticks (counted up to its rising edge) is at least the leader-min value and at most the leader-max value. A leader starts a frame and busy goes to 1. The first falling edge after the leader opens the cycle of bit 0.
- R3: In leader mode, a low pulse narrower than leader-min is ignored: busy stays 0 and no flag is raised.
- R4: A low pulse wider than leader-max, seen while waiting, gives a one-cycle leaderErr pulse. The receiver keeps waiting.
- R5: When the leader-optional bit is 1, a low pulse narrower than leader-min starts a frame with no leader. The falling edge of that pulse opens the cycle of bit 0.
- R6: Once a frame has started, if the number of ticks since the last falling edge (or since the leader ended) reaches cycle-max with no new falling edge, the frame ends. frameDone pulses for one cycle, rxData and rxBits take the frame's values, and busy returns to 0.
- R7: Each falling edge inside a frame closes one bit. The bit is 1 if the falling-edge-to-falling-edge spacing in ticks is at least bit-threshold, and 0 otherwise. Bit n lands in rxData[n]. rxBits counts the bits and stops at 32; bits after the 32nd are dropped.
- R8: Setting rxEnable to 0 abandons a frame at once. busy is 0 on the next cycle, no frameDone is given, and rxData and rxBits keep their earlier values.
- R9: A register write made during a frame does not change how that frame is decoded. The new value applies once the receiver is waiting again.
- R10: Register addresses are 0 leader-min, 1 leader-max, 2 cycle-max, 3 bit-threshold, and 4 the leader-optional mode (bit 0). After reset their values are 16, 48, 64, 10 and 0.
- R11: Width and spacing counters saturate at 255. A low pulse longer than 255 ticks is measured as 255, so with leader-max at 255 it is still accepted as a leader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address |
| cfgWdata | input | 8 | Register write data |
| rxEnable | input | 1 | Reception enable |
| irIn | input | 1 | Raw demodulated line, idle high |
| tick | input | 1 | Sampling tick, one clock wide |
| busy | output | 1 | A frame is in progress |
| frameDone | output | 1 | One-cycle pulse when a frame ends |
| leaderErr | output | 1 | One-cycle pulse for a leader that is too wide |
| rxData | output | 32 | Bits of the last finished frame |
| rxBits | output | 6 | Bit count of the last finished frame |

## Verification
The hardest states to reach from the ports are inside a live frame: a register write that lands between two bit pulses, a disable that cuts a frame short, and a frame longer than the 32-bit data register. The stimulus reaches them by inserting the write or the disable between the bit pulses of a frame that has already started, and by sending a 36-bit frame. A behavioural model tracks every tick, so the synchronizer delay and tick alignment never have to be predicted by hand. The leader-less start is checked in the same way, with a frame that begins directly on a short pulse while the mode bit is set.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  localparam int CNT_W = 8;
  localparam int ADDR_LEAD_MIN = 0;
  localparam int ADDR_LEAD_MAX = 1;
  localparam int ADDR_CYC_MAX  = 2;
  localparam int ADDR_BIT_THR  = 3;
  localparam int ADDR_MODE     = 4;

  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_TOP = '1;

  typedef struct packed {
    cnt_t leadMin;
    cnt_t leadMax;
    cnt_t cycMax;
    cnt_t bitThr;
    logic leadOpt;
  } rxCfg_t;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } rxState_t;

  // control -> datapath
  typedef struct packed {
    logic loadCfg;
    logic clearWork;
    logic armCycle;
    logic pushBit;
    logic endFrame;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic tickEv;
    logic fall;
    logic rise;
    logic leadInRange;
    logic leadTooWide;
    logic leadOptMode;
    logic cycleExpired;
  } dpStatus_t;

  function automatic cnt_t satInc(cnt_t v);
    return (v == CNT_TOP) ? v : cnt_t'(v + 1'b1);
  endfunction
endpackage

// File: rtl/irrx_datapath.sv
module irrx_datapath import irrx_pkg::*; #(
  parameter int   DATA_W       = 32,
  parameter int   ADDR_W       = 3,
  parameter int   SYNC_STAGES  = 2,
  parameter int   BITS_W       = $clog2(DATA_W + 1),
  parameter cnt_t RST_LEAD_MIN = 8'd16,
  parameter cnt_t RST_LEAD_MAX = 8'd48,
  parameter cnt_t RST_CYC_MAX  = 8'd64,
  parameter cnt_t RST_BIT_THR  = 8'd10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgWdata,
  input  logic              irIn,
  input  logic              tick,
  input  logic              busy,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  output logic [DATA_W-1:0] rxData,
  output logic [BITS_W-1:0] rxBits
);
  localparam rxCfg_t RST_CFG = '{
    leadMin: RST_LEAD_MIN, leadMax: RST_LEAD_MAX,
    cycMax: RST_CYC_MAX, bitThr: RST_BIT_THR, leadOpt: 1'b0};
  localparam logic [BITS_W-1:0] BITS_CAP = BITS_W'(DATA_W);

  // input synchronizer
  logic [SYNC_STAGES-1:0] syncChain;
  logic sLvl;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '1;
        else       syncChain <= irIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], irIn};
    end
  endgenerate
  assign sLvl = syncChain[SYNC_STAGES-1];

  // tick-domain edge detection and width counters
  logic prevLvl;
  cnt_t lowCnt, cycCnt;
  logic fallEv, riseEv;
  assign fallEv = tick && prevLvl && !sLvl;
  assign riseEv = tick && !prevLvl && sLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl <= 1'b1;
      lowCnt  <= '0;
      cycCnt  <= CNT_TOP;
    end else if (tick) begin
      prevLvl <= sLvl;
      lowCnt  <= sLvl ? '0 : satInc(lowCnt);
      cycCnt  <= (fallEv || strobe.armCycle) ? cnt_t'(1) : satInc(cycCnt);
    end
  end

  // configuration: shadow written any time, active copied while idle
  rxCfg_t shadowCfg, activeCfg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCfg <= RST_CFG;
      activeCfg <= RST_CFG;
    end else begin
      if (strobe.loadCfg) activeCfg <= shadowCfg;
      if (cfgWe) begin
        if (cfgAddr == ADDR_W'(ADDR_LEAD_MIN)) shadowCfg.leadMin <= cfgWdata;
        if (cfgAddr == ADDR_W'(ADDR_LEAD_MAX)) shadowCfg.leadMax <= cfgWdata;
        if (cfgAddr == ADDR_W'(ADDR_CYC_MAX))  shadowCfg.cycMax  <= cfgWdata;
        if (cfgAddr == ADDR_W'(ADDR_BIT_THR))  shadowCfg.bitThr  <= cfgWdata;
        if (cfgAddr == ADDR_W'(ADDR_MODE))     shadowCfg.leadOpt <= cfgWdata[0];
      end
    end
  end

  // comparisons handed to control
  logic bitVal;
  assign bitVal = (cycCnt >= activeCfg.bitThr);
  assign status.tickEv       = tick;
  assign status.fall         = fallEv;
  assign status.rise         = riseEv;
  assign status.leadInRange  = (lowCnt >= activeCfg.leadMin) && (lowCnt <= activeCfg.leadMax);
  assign status.leadTooWide  = (lowCnt > activeCfg.leadMax);
  assign status.leadOptMode  = activeCfg.leadOpt;
  assign status.cycleExpired = (cycCnt >= activeCfg.cycMax);

  // working frame register
  logic [DATA_W-1:0] workData;
  logic [BITS_W-1:0] workCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workData <= '0;
      workCnt  <= '0;
    end else if (strobe.clearWork) begin
      workData <= '0;
      workCnt  <= '0;
    end else if (strobe.pushBit && (workCnt < BITS_CAP)) begin
      for (int i = 0; i < DATA_W; i++)
        if (workCnt == BITS_W'(i)) workData[i] <= bitVal;
      workCnt <= workCnt + 1'b1;
    end
  end

  // posted frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxBits <= '0;
    end else if (strobe.endFrame) begin
      rxData <= workData;
      rxBits <= workCnt;
    end
  end

  p_bits_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxBits <= BITS_CAP);
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(activeCfg));
  p_lowcnt_sat_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lowCnt) == CNT_TOP && !sLvl && $past(!sLvl)) |-> lowCnt == CNT_TOP);
endmodule

// File: rtl/irrx_control.sv
module irrx_control import irrx_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEnable,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        frameDone,
  output logic        leaderErr
);
  rxState_t state, nextState;
  logic setDone, setErr;

  always_comb begin
    nextState      = state;
    strobe         = '0;
    setDone        = 1'b0;
    setErr         = 1'b0;
    strobe.loadCfg = (state == ST_OFF) || (state == ST_WAIT);
    if (!rxEnable) begin
      nextState        = ST_OFF;
      strobe.clearWork = 1'b1;
    end else begin
      case (state)
        ST_OFF: nextState = ST_WAIT;
        ST_WAIT: begin
          if (status.rise) begin
            if (status.leadTooWide) begin
              setErr = 1'b1;
            end else if (status.leadInRange) begin
              nextState        = ST_GAP;
              strobe.clearWork = 1'b1;
              strobe.armCycle  = 1'b1;
            end else if (status.leadOptMode) begin
              nextState        = ST_DATA;
              strobe.clearWork = 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (status.fall) begin
            nextState = ST_DATA;
          end else if (status.tickEv && status.cycleExpired) begin
            nextState       = ST_WAIT;
            strobe.endFrame = 1'b1;
            setDone         = 1'b1;
          end
        end
        ST_DATA: begin
          if (status.fall) begin
            strobe.pushBit = 1'b1;
          end else if (status.tickEv && status.cycleExpired) begin
            nextState       = ST_WAIT;
            strobe.endFrame = 1'b1;
            setDone         = 1'b1;
          end
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      frameDone <= 1'b0;
      leaderErr <= 1'b0;
    end else begin
      state     <= nextState;
      frameDone <= setDone;
      leaderErr <= setErr;
    end
  end

  assign busy = (state == ST_GAP) || (state == ST_DATA);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !busy);
  p_err_while_waiting_r4: assert property (@(posedge clk) disable iff (!rstN)
    leaderErr |-> !busy);
  p_done_after_frame_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(busy));
  p_single_event_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(frameDone && leaderErr));
endmodule

// File: rtl/irrx_receiver.sv
module irrx_receiver import irrx_pkg::*; #(
  parameter int   DATA_W       = 32,
  parameter int   ADDR_W       = 3,
  parameter int   SYNC_STAGES  = 2,
  parameter int   BITS_W       = $clog2(DATA_W + 1),
  parameter cnt_t RST_LEAD_MIN = 8'd16,
  parameter cnt_t RST_LEAD_MAX = 8'd48,
  parameter cnt_t RST_CYC_MAX  = 8'd64,
  parameter cnt_t RST_BIT_THR  = 8'd10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgWdata,
  input  logic              rxEnable,
  input  logic              irIn,
  input  logic              tick,
  output logic              busy,
  output logic              frameDone,
  output logic              leaderErr,
  output logic [DATA_W-1:0] rxData,
  output logic [BITS_W-1:0] rxBits
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  irrx_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .BITS_W(BITS_W),
    .RST_LEAD_MIN(RST_LEAD_MIN), .RST_LEAD_MAX(RST_LEAD_MAX),
    .RST_CYC_MAX(RST_CYC_MAX), .RST_BIT_THR(RST_BIT_THR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .irIn(irIn), .tick(tick), .busy(busy), .strobe(strobe), .status(status),
    .rxData(rxData), .rxBits(rxBits)
  );

  irrx_control u_ctl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .status(status), .strobe(strobe),
    .busy(busy), .frameDone(frameDone), .leaderErr(leaderErr)
  );

  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |-> ($stable(rxData) && $stable(rxBits)));
endmodule

// File: tb/tb_irrx_receiver.sv
module tb_irrx_receiver;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [7:0]  cfgWdata = '0;
  logic        rxEnable = 1'b0;
  logic        irIn = 1'b1;
  logic        tick = 1'b0;
  logic        busy, frameDone, leaderErr;
  logic [31:0] rxData;
  logic [5:0]  rxBits;

  int total = 0;
  int bad = 0;
  int doneSeen = 0;
  int errSeen = 0;
  int busySeen = 0;

  always #5 clk = ~clk;

  irrx_receiver dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .rxEnable(rxEnable), .irIn(irIn), .tick(tick), .busy(busy),
    .frameDone(frameDone), .leaderErr(leaderErr), .rxData(rxData), .rxBits(rxBits)
  );

  // ---------------- behavioural reference ----------------
  int pipe[$];
  int mState, mPrev, mLow, mCyc, mCnt, mBits;
  int shadow[5];
  int active[5];
  logic [31:0] mWork, mData;
  bit mDone, mErr;

  function automatic int sat(int v);
    return (v >= 255) ? 255 : v + 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      pipe = {1, 1};
      mState = 0; mPrev = 1; mLow = 0; mCyc = 255; mCnt = 0; mBits = 0;
      shadow = '{16, 48, 64, 10, 0};
      active = '{16, 48, 64, 10, 0};
      mWork = '0; mData = '0; mDone = 0; mErr = 0;
    end else begin
      int lvl, nState;
      bit fl, rs, arm, nDone, nErr;
      lvl = pipe.pop_front();
      pipe.push_back(int'(irIn));
      fl = tick && mPrev == 1 && lvl == 0;
      rs = tick && mPrev == 0 && lvl == 1;
      nState = mState; nDone = 0; nErr = 0; arm = 0;
      if (!rxEnable) begin
        nState = 0; mWork = '0; mCnt = 0;
      end else begin
        case (mState)
          0: nState = 1;
          1: if (rs) begin
               if (mLow > active[1]) nErr = 1;
               else if (mLow >= active[0]) begin nState = 2; mWork = '0; mCnt = 0; arm = 1; end
               else if (active[4] != 0) begin nState = 3; mWork = '0; mCnt = 0; end
             end
          default: begin
            if (fl) begin
              if (mState == 3 && mCnt < 32) begin
                mWork[mCnt] = (mCyc >= active[3]);
                mCnt++;
              end
              nState = 3;
            end else if (tick && mCyc >= active[2]) begin
              mData = mWork; mBits = mCnt; nDone = 1; nState = 1;
            end
          end
        endcase
      end
      if (tick) begin
        mLow = (lvl == 1) ? 0 : sat(mLow);
        mCyc = (fl || arm) ? 1 : sat(mCyc);
        mPrev = lvl;
      end
      if (mState <= 1) active = shadow;
      if (cfgWe && cfgAddr <= 3) shadow[cfgAddr] = int'(cfgWdata);
      if (cfgWe && cfgAddr == 4) shadow[4] = int'(cfgWdata[0]);
      mState = nState; mDone = nDone; mErr = nErr;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      if (frameDone) doneSeen++;
      if (leaderErr) errSeen++;
      if (busy) busySeen++;
      chk("R6 model frameDone", int'(frameDone), int'(mDone));
      chk("R4 model leaderErr", int'(leaderErr), int'(mErr));
      chk("R2 model busy", int'(busy), int'(mState >= 2));
      chk("R7 model rxData", int'(rxData), int'(mData));
      chk("R7 model rxBits", int'(rxBits), mBits);
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tick = (tc == 3);
      tc = (tc + 1) % 4;
    end
  end

  task automatic waitTicks(int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic cfgWrite(int a, int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 3'(a); cfgWdata = 8'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulse(int lowT, int highT);
    irIn = 1'b0; waitTicks(lowT);
    irIn = 1'b1; waitTicks(highT);
  endtask

  task automatic sendBits(logic [63:0] d, int n);
    for (int i = 0; i < n; i++) pulse(3, d[i] ? 14 : 4);
  endtask

  task automatic frame(bit lead, logic [63:0] d, int n);
    if (lead) pulse(24, 10);
    sendBits(d, n);
    pulse(3, 80);
  endtask

  initial begin
    logic [31:0] held;
    int d0;
    int e0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset rxData", int'(rxData), 0);
    chk("R1 reset rxBits", int'(rxBits), 0);

    // disabled: no reception
    frame(1, 64'hF0, 8);
    chk("R1 disabled no busy", busySeen, 0);
    chk("R1 disabled no done", doneSeen, 0);

    // default registers
    rxEnable = 1'b1; waitTicks(5);
    frame(1, 64'hA5, 8);
    chk("R10 default frame done", doneSeen, 1);
    chk("R7 data A5", int'(rxData), 32'hA5);
    chk("R7 bits 8", int'(rxBits), 8);

    cfgWrite(0, 20); cfgWrite(1, 30); cfgWrite(2, 40); cfgWrite(3, 12);
    waitTicks(3);

    // narrow pulse ignored in leader mode
    busySeen = 0; e0 = errSeen;
    pulse(5, 60);
    chk("R3 narrow no busy", busySeen, 0);
    chk("R3 narrow no err", errSeen, e0);

    // wide leader error
    pulse(40, 60);
    chk("R4 wide err pulse", errSeen, e0 + 1);
    chk("R4 still waiting", int'(busy), 0);

    // normal frame with leader
    d0 = doneSeen;
    frame(1, 64'h3C96, 16);
    chk("R2 leader frame done", doneSeen, d0 + 1);
    chk("R6 data", int'(rxData), 32'h3C96);
    chk("R6 bits", int'(rxBits), 16);

    // leader-optional
    cfgWrite(4, 1); waitTicks(3);
    frame(0, 64'h5B, 7);
    chk("R5 no-leader done", doneSeen, d0 + 2);
    chk("R5 no-leader data", int'(rxData), 32'h5B);
    chk("R5 no-leader bits", int'(rxBits), 7);
    cfgWrite(4, 0); waitTicks(3);

    // overlong frame
    frame(1, 64'hF_1234_5678, 36);
    chk("R7 cap bits", int'(rxBits), 32);
    chk("R7 cap data", int'(rxData), 32'h1234_5678);

    // abort mid-frame
    held = rxData; d0 = doneSeen;
    pulse(24, 10); sendBits(64'h0F, 5);
    chk("R8 busy before abort", int'(busy), 1);
    rxEnable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 abort busy", int'(busy), 0);
    waitTicks(60);
    chk("R8 abort no done", doneSeen, d0);
    chk("R8 abort data held", int'(rxData), int'(held));
    rxEnable = 1'b1; waitTicks(5);

    // config write during frame
    pulse(24, 10); sendBits(64'h0D, 4);
    cfgWrite(3, 100);
    sendBits(64'h0A, 4);
    pulse(3, 80);
    chk("R9 frame keeps old threshold", int'(rxData), 32'hAD);
    frame(1, 64'hFF, 8);
    chk("R9 new threshold applied", int'(rxData), 32'h00);
    chk("R9 new threshold bits", int'(rxBits), 8);
    cfgWrite(3, 12);

    // saturating width counter
    cfgWrite(0, 200); cfgWrite(1, 255); waitTicks(3);
    e0 = errSeen;
    pulse(300, 10); sendBits(64'h6, 3); pulse(3, 80);
    chk("R11 saturated leader accepted", int'(rxData), 6);
    chk("R11 no error", errSeen, e0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule